// File: doc/BRIEF.md
# Speculative Reorder Buffer with In-Order Retirement

This block keeps every in-flight instruction of an out-of-order core in a circular queue, in the order the front end issued them, and retires them one at a time from the oldest end. The issuer requests an entry on the allocate port and receives a small tag that names the entry. Execution units later return results on a tagged result bus. Store instructions deliver their effective address on a separate port. A combinational lookup port lets younger instructions read a finished but not yet retired value by tag. A second query port tells a load whether an older store could still alias it.

Only the oldest entry can retire, and only once its result is present. A register-producing entry then drives a register-file write, and a store drives a memory write. A branch reports its resolution. A branch that was mispredicted empties the whole buffer. A fault reported by an execution unit is kept in the entry and only appears when that entry reaches the head. At that point it produces no architectural write and also empties the buffer.

Top module: `rob_core`

## Requirements
- R1: `alloc_tag` always shows the slot the next allocation takes. Tags are handed out 0,1,2,… modulo DEPTH (8). `alloc_ready` is low while DEPTH entries are live, and an allocation in that state is dropped.
- R2: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, and no retire, flush or lookup-hit output is active.
- R3: A result-bus write (`cdb_valid`) to a live tag stores `cdb_value`, the fault flag and the mispredict flag, and marks the entry done. A write to a tag that is not live changes nothing. The stored value is what the entry later retires with.
- R4: `lk_hit` is 1 only when `lk_tag` names a live entry that is done, and `lk_value` then carries its result.
- R5: At most one entry retires per cycle. It is always the oldest one, and only when it is done; a store also needs its address, unless it is faulted. Younger done entries wait.
- R6: A retiring register operation (type 2'b10) drives `cm_reg_we` with its register number on `cm_reg_idx`.
- R7: A retiring store (type 2'b01) drives `cm_st_we` with `cm_st_addr` and `cm_st_data`. `st_addr_valid` records an address only for a live store entry.
- R8: A retiring branch (type 2'b00) drives `cm_br_valid`, and `cm_br_mispred` shows its recorded outcome. A mispredicted branch triggers a flush; a correctly predicted one does not.
- R9: A faulted entry signals `cm_exc` only when it retires. It then drives no register or memory write and triggers a flush.
- R10: `ld_block` is 1 when a live store sits between the head and the queried `ld_tag` (exclusive) and either has no address yet or has one equal to `ld_addr`. Stores at or after `ld_tag` never block.
- R11: In a flush cycle `alloc_ready` is low, and all writes and allocations are ignored. In the next cycle the buffer is empty and `alloc_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_type | input | 2 | 00 branch, 01 store, 10 register operation |
| alloc_reg | input | RW | Destination register number |
| alloc_ready | output | 1 | Allocation accepted this cycle |
| alloc_tag | output | IW | Tag of the slot being allocated |
| cdb_valid | input | 1 | Result bus write |
| cdb_tag | input | IW | Entry receiving the result |
| cdb_value | input | DW | Result or store data |
| cdb_exc | input | 1 | Instruction faulted |
| cdb_mispred | input | 1 | Branch was mispredicted |
| st_addr_valid | input | 1 | Store address write |
| st_addr_tag | input | IW | Store entry receiving the address |
| st_addr | input | AW | Store effective address |
| lk_tag | input | IW | Operand lookup tag |
| lk_hit | output | 1 | Lookup found a finished value |
| lk_value | output | DW | Forwarded value |
| ld_tag | input | IW | Tag of the querying load |
| ld_addr | input | AW | Load effective address |
| ld_block | output | 1 | Load must wait for an older store |
| cm_reg_we | output | 1 | Register-file write at retire |
| cm_reg_idx | output | RW | Register number written |
| cm_reg_val | output | DW | Register value written |
| cm_st_we | output | 1 | Memory write at retire |
| cm_st_addr | output | AW | Store address |
| cm_st_data | output | DW | Store data |
| cm_br_valid | output | 1 | Branch retires |
| cm_br_mispred | output | 1 | Retiring branch was mispredicted |
| cm_exc | output | 1 | Faulted entry retires |
| flush | output | 1 | Buffer is emptied at this edge |

## Verification
The hardest state to reach is a full buffer whose head is a store with a missing address, while results keep landing on younger entries. It matters because that is where retirement stalls and loads behind the store must stay blocked. Stimulus runs in phases with different rates of allocation, completion and address delivery. One phase uses a high allocation rate with sparse completions, which fills all eight slots and holds stores unresolved. Other phases raise the fault and mispredict rates to make flushes frequent. Every cycle, all outputs are compared against a queue-based model in the bench.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
    typedef enum logic [1:0] {
        OP_BRANCH = 2'b00,
        OP_STORE  = 2'b01,
        OP_REGWR  = 2'b10
    } op_kind_e;
endpackage

// File: rtl/rob_fwd_mux.sv
`timescale 1ns/1ps
module rob_fwd_mux #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]         ent_vld,
    input  logic [DEPTH-1:0]         ent_rdy,
    input  logic [DEPTH-1:0][DW-1:0] ent_val,
    input  logic [IW-1:0]            q_tag,
    output logic                     hit,
    output logic [DW-1:0]            value
);
    // operand forwarding: a done, unretired entry answers by its tag
    always_comb begin
        hit   = ent_vld[q_tag] & ent_rdy[q_tag];
        value = ent_val[q_tag];
    end
endmodule

// File: rtl/rob_ld_check.sv
`timescale 1ns/1ps
module rob_ld_check #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic [IW-1:0]            head,
    input  logic [DEPTH-1:0]         ent_vld,
    input  logic [DEPTH-1:0]         ent_store,
    input  logic [DEPTH-1:0]         ent_av,
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [IW-1:0]            ld_tag,
    input  logic [AW-1:0]            ld_addr,
    output logic                     block
);
    logic [IW-1:0]    ld_age;
    logic [DEPTH-1:0] hazard;

    assign ld_age = ld_tag - head;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [IW-1:0] SLOT = IW'(i);
        logic [IW-1:0] age;
        logic          older;
        assign age   = SLOT - head;
        assign older = age < ld_age;
        // an older store blocks when its address is unknown or equal
        assign hazard[i] = ent_vld[i] & ent_store[i] & older &
                           (~ent_av[i] | (ent_addr[i] == ld_addr));
    end

    assign block = |hazard;
endmodule

// File: rtl/rob_core.sv
`timescale 1ns/1ps
module rob_core #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int RW    = 5,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic [1:0]    alloc_type,
    input  logic [RW-1:0] alloc_reg,
    output logic          alloc_ready,
    output logic [IW-1:0] alloc_tag,
    input  logic          cdb_valid,
    input  logic [IW-1:0] cdb_tag,
    input  logic [DW-1:0] cdb_value,
    input  logic          cdb_exc,
    input  logic          cdb_mispred,
    input  logic          st_addr_valid,
    input  logic [IW-1:0] st_addr_tag,
    input  logic [AW-1:0] st_addr,
    input  logic [IW-1:0] lk_tag,
    output logic          lk_hit,
    output logic [DW-1:0] lk_value,
    input  logic [IW-1:0] ld_tag,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_block,
    output logic          cm_reg_we,
    output logic [RW-1:0] cm_reg_idx,
    output logic [DW-1:0] cm_reg_val,
    output logic          cm_st_we,
    output logic [AW-1:0] cm_st_addr,
    output logic [DW-1:0] cm_st_data,
    output logic          cm_br_valid,
    output logic          cm_br_mispred,
    output logic          cm_exc,
    output logic          flush
);
    import rob_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0]         rdy;
        logic [DEPTH-1:0]         exc;
        logic [DEPTH-1:0]         mis;
        logic [DEPTH-1:0]         av;
        logic [DEPTH-1:0][1:0]    kind;
        logic [DEPTH-1:0][RW-1:0] rd;
        logic [DEPTH-1:0][DW-1:0] val;
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [IW-1:0]            head;
        logic [IW-1:0]            tail;
        logic [CW-1:0]            cnt;
    } rob_state_t;

    rob_state_t st_q, st_d;

    logic          hd_vld, hd_go, hd_exc, retire, do_alloc;
    logic [1:0]    hd_kind;
    logic [DEPTH-1:0] is_store;

    // head decode and retire decision
    always_comb begin
        hd_vld  = st_q.vld[st_q.head];
        hd_kind = st_q.kind[st_q.head];
        hd_exc  = st_q.exc[st_q.head];
        hd_go   = hd_vld & st_q.rdy[st_q.head] &
                  (hd_exc | (hd_kind != OP_STORE) | st_q.av[st_q.head]);
        retire  = hd_go;
        flush   = retire & (hd_exc | ((hd_kind == OP_BRANCH) & st_q.mis[st_q.head]));
        alloc_ready = (st_q.cnt != FULL_CNT) & ~flush;
        do_alloc    = alloc_valid & alloc_ready;
        alloc_tag   = st_q.tail;

        cm_exc        = retire & hd_exc;
        cm_reg_we     = retire & ~hd_exc & (hd_kind == OP_REGWR);
        cm_reg_idx    = st_q.rd[st_q.head];
        cm_reg_val    = st_q.val[st_q.head];
        cm_st_we      = retire & ~hd_exc & (hd_kind == OP_STORE);
        cm_st_addr    = st_q.addr[st_q.head];
        cm_st_data    = st_q.val[st_q.head];
        cm_br_valid   = retire & ~hd_exc & (hd_kind == OP_BRANCH);
        cm_br_mispred = st_q.mis[st_q.head];

        for (int i = 0; i < DEPTH; i++) begin
            is_store[i] = (st_q.kind[i] == OP_STORE);
        end
    end

    // next-state computation
    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.vld  = '0;
            st_d.head = '0;
            st_d.tail = '0;
            st_d.cnt  = '0;
        end else begin
            if (cdb_valid && st_q.vld[cdb_tag]) begin
                st_d.val[cdb_tag] = cdb_value;
                st_d.rdy[cdb_tag] = 1'b1;
                st_d.exc[cdb_tag] = cdb_exc;
                st_d.mis[cdb_tag] = cdb_mispred;
            end
            if (st_addr_valid && st_q.vld[st_addr_tag] && is_store[st_addr_tag]) begin
                st_d.addr[st_addr_tag] = st_addr;
                st_d.av[st_addr_tag]   = 1'b1;
            end
            if (retire) begin
                st_d.vld[st_q.head] = 1'b0;
                st_d.head           = st_q.head + 1'b1;
            end
            if (do_alloc) begin
                st_d.vld[st_q.tail]  = 1'b1;
                st_d.rdy[st_q.tail]  = 1'b0;
                st_d.exc[st_q.tail]  = 1'b0;
                st_d.mis[st_q.tail]  = 1'b0;
                st_d.av[st_q.tail]   = 1'b0;
                st_d.kind[st_q.tail] = alloc_type;
                st_d.rd[st_q.tail]   = alloc_reg;
                st_d.tail            = st_q.tail + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(do_alloc) - CW'(retire);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rob_fwd_mux #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_fwd (
        .ent_vld (st_q.vld),
        .ent_rdy (st_q.rdy),
        .ent_val (st_q.val),
        .q_tag   (lk_tag),
        .hit     (lk_hit),
        .value   (lk_value)
    );

    rob_ld_check #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_ldchk (
        .head      (st_q.head),
        .ent_vld   (st_q.vld),
        .ent_store (is_store),
        .ent_av    (st_q.av),
        .ent_addr  (st_q.addr),
        .ld_tag    (ld_tag),
        .ld_addr   (ld_addr),
        .block     (ld_block)
    );

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT); // R1
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL_CNT) |-> !alloc_ready); // R1
    AST_ALLOC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && !retire) |=> st_q.cnt == $past(st_q.cnt) + 1'b1); // R1
    AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cm_reg_we, cm_st_we, cm_br_valid, cm_exc})); // R5
    AST_RETIRE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !flush && !(alloc_valid && alloc_ready)) |=> st_q.cnt == $past(st_q.cnt) - 1'b1); // R5
    AST_EXC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cm_exc |-> !(cm_reg_we || cm_st_we || cm_br_valid)); // R9
    AST_EXC_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        cm_exc |-> flush); // R9
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0) && (alloc_tag == '0) && !lk_hit); // R11
endmodule

// File: tb/rob_core_tb.sv
`timescale 1ns/1ps
module rob_core_tb_top;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 0;
    logic [1:0]  alloc_type = 0;
    logic [4:0]  alloc_reg = 0;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic        cdb_valid = 0;
    logic [2:0]  cdb_tag = 0;
    logic [31:0] cdb_value = 0;
    logic        cdb_exc = 0, cdb_mispred = 0;
    logic        st_addr_valid = 0;
    logic [2:0]  st_addr_tag = 0;
    logic [31:0] st_addr = 0;
    logic [2:0]  lk_tag = 0;
    logic        lk_hit;
    logic [31:0] lk_value;
    logic [2:0]  ld_tag = 0;
    logic [31:0] ld_addr = 0;
    logic        ld_block;
    logic        cm_reg_we, cm_st_we, cm_br_valid, cm_br_mispred, cm_exc, flush;
    logic [4:0]  cm_reg_idx;
    logic [31:0] cm_reg_val, cm_st_addr, cm_st_data;

    always #5 clk = ~clk;

    rob_core dut_i (.*);

    typedef struct {
        int unsigned kind;
        bit [4:0]    rd;
        bit [31:0]   val;
        bit          rdy;
        bit          av;
        bit [31:0]   addr;
        bit          exc;
        bit          mis;
    } ent_t;

    ent_t q[$];
    int   head_tag = 0;
    int   n_cmp = 0, n_bad = 0;
    bit   done = 0;

    task automatic chk(input string rq, input string nm, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, nm, act, exp, $time);
        end
    endtask

    function automatic int find(input int tag);
        int p = (tag - head_tag + D) % D;
        return (p < q.size()) ? p : -1;
    endfunction

    function automatic bit mdl_retire();
        if (q.size() == 0) return 0;
        return q[0].rdy && (q[0].exc || q[0].kind != 1 || q[0].av);
    endfunction

    function automatic bit mdl_flush();
        return mdl_retire() && (q[0].exc || (q[0].kind == 0 && q[0].mis));
    endfunction

    task automatic compare_now();
        bit rt = mdl_retire();
        bit fl = mdl_flush();
        bit ar = (q.size() < D) && !fl;
        bit rw = rt && !q[0].exc && q[0].kind == 2;
        bit sw = rt && !q[0].exc && q[0].kind == 1;
        bit bv = rt && !q[0].exc && q[0].kind == 0;
        bit ex = rt && q[0].exc;
        int p  = find(lk_tag);
        bit hit = (p >= 0) && q[p].rdy;
        int lp = (ld_tag - head_tag + D) % D;
        bit blk = 0;
        for (int i = 0; i < q.size() && i < lp; i++)
            if (q[i].kind == 1 && (!q[i].av || q[i].addr == ld_addr)) blk = 1;
        chk("R1", "alloc_ready", alloc_ready, ar);
        chk("R1", "alloc_tag", alloc_tag, (head_tag + q.size()) % D);
        chk("R5", "retire", cm_reg_we | cm_st_we | cm_br_valid | cm_exc, rt);
        chk("R6", "cm_reg_we", cm_reg_we, rw);
        if (rw) begin
            chk("R6", "cm_reg_idx", cm_reg_idx, q[0].rd);
            chk("R3", "cm_reg_val", cm_reg_val, q[0].val);
        end
        chk("R7", "cm_st_we", cm_st_we, sw);
        if (sw) begin
            chk("R7", "cm_st_addr", cm_st_addr, q[0].addr);
            chk("R7", "cm_st_data", cm_st_data, q[0].val);
        end
        chk("R8", "cm_br_valid", cm_br_valid, bv);
        if (bv) chk("R8", "cm_br_mispred", cm_br_mispred, q[0].mis);
        chk("R9", "cm_exc", cm_exc, ex);
        chk("R11", "flush", flush, fl);
        chk("R4", "lk_hit", lk_hit, hit);
        if (hit) chk("R4", "lk_value", lk_value, q[p].val);
        chk("R10", "ld_block", ld_block, blk);
    endtask

    task automatic model_step();
        bit rt = mdl_retire();
        bit ar = (q.size() < D) && !mdl_flush();
        if (mdl_flush()) begin
            q.delete();
            head_tag = 0;
            return;
        end
        if (cdb_valid) begin
            int p = find(cdb_tag);
            if (p >= 0) begin
                q[p].val = cdb_value; q[p].rdy = 1;
                q[p].exc = cdb_exc;   q[p].mis = cdb_mispred;
            end
        end
        if (st_addr_valid) begin
            int p = find(st_addr_tag);
            if (p >= 0 && q[p].kind == 1) begin
                q[p].addr = st_addr; q[p].av = 1;
            end
        end
        if (rt) begin
            void'(q.pop_front());
            head_tag = (head_tag + 1) % D;
        end
        if (alloc_valid && ar) begin
            ent_t e;
            e.kind = alloc_type; e.rd = alloc_reg; e.val = 0; e.rdy = 0;
            e.av = 0; e.addr = 0; e.exc = 0; e.mis = 0;
            q.push_back(e);
        end
    endtask

    function automatic logic [2:0] pick_tag();
        if (q.size() > 0 && ($urandom % 100) < 85)
            return 3'((head_tag + int'($urandom % q.size())) % D);
        return 3'($urandom % D);
    endfunction

    task automatic run_phase(input int n, input int pa, input int pc, input int ps,
                             input int pm, input int pe);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            alloc_valid   = ($urandom % 100) < pa;
            alloc_type    = 2'($urandom % 3);
            alloc_reg     = 5'($urandom);
            cdb_valid     = ($urandom % 100) < pc;
            cdb_tag       = pick_tag();
            cdb_value     = $urandom;
            cdb_exc       = ($urandom % 100) < pe;
            cdb_mispred   = ($urandom % 100) < pm;
            st_addr_valid = ($urandom % 100) < ps;
            st_addr_tag   = pick_tag();
            st_addr       = $urandom % 4;
            lk_tag        = pick_tag();
            ld_tag        = pick_tag();
            ld_addr       = $urandom % 4;
            #1 compare_now();
            @(posedge clk);
            model_step();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state
        chk("R2", "alloc_ready", alloc_ready, 1);
        chk("R2", "alloc_tag", alloc_tag, 0);
        chk("R2", "retire", cm_reg_we | cm_st_we | cm_br_valid | cm_exc, 0);
        chk("R2", "flush", flush, 0);
        chk("R2", "lk_hit", lk_hit, 0);
        // fill to full with no completions (R1)
        run_phase(12, 100, 0, 0, 0, 0);
        // drain with completions and addresses
        run_phase(40, 0, 80, 80, 0, 0);
        // mixed traffic, no faults
        run_phase(800, 60, 40, 40, 0, 0);
        // buffer kept near full, stores often unresolved (R10)
        run_phase(800, 90, 20, 10, 0, 0);
        // frequent mispredicts and faults (R8, R9, R11)
        run_phase(800, 70, 50, 50, 30, 10);
        // sparse traffic
        run_phase(600, 20, 60, 60, 10, 3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule